// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block sits between a register bus and a serial audio engine. It holds two 32-word queues: one carries words written by software towards the serializer, the other carries words captured by the serializer back towards software. Both fill levels are published in one status word. Each direction raises a sticky request flag when its fill level crosses a programmable level, so that a CPU or a DMA engine knows when to refill the outbound queue or drain the inbound one.

Each request flag can drive an interrupt output through its own enable. Software clears a flag with a one-cycle clear pulse, which models writing zero to the flag bit. If the level condition still holds, the flag sets again on the following cycle. Each queue also has its own hold input that empties it and keeps it empty. This hold is separate from the block reset, so one direction can be flushed while the other keeps running.

Top module: `audio_fifo_req`

## Requirements
- R1: Each queue holds up to 32 words. The status word reports the outbound fill count in bits 29:24 and the inbound fill count in bits 13:8, each as a 6-bit value from 0 to 32. All other status bits, apart from the two flags, read 0.
- R2: Words leave each queue in the order they entered. `ser_tx_valid` is 1 exactly when the outbound queue is not empty, and `ser_tx_data` then shows its oldest word.
- R3: A bus write to a full outbound queue is dropped, and `tx_overflow` is 1 in that same cycle. This holds even if the serializer pops in that cycle.
- R4: A bus read of an empty inbound queue returns 0 on `rx_rd_data`, `rx_underflow` is 1 in that same cycle, and the count stays 0.
- R5: The outbound request flag is status bit 16. It becomes 1 one cycle after a cycle in which the outbound count is at or below `tx_level`, and it stays 1 until cleared.
- R6: The inbound request flag is status bit 0. It becomes 1 one cycle after a cycle in which the inbound count is above `rx_level`. With `rx_level` at 0, a single stored word sets it.
- R7: A clear pulse drives its flag to 0 on the next cycle. If the level condition still holds in that cycle, the flag returns to 1 one cycle later.
- R8: While a hold input is 1, its queue's count is 0 from the next edge on, and pushes and pops to that queue have no effect.
- R9: `tx_irq` equals the outbound flag AND `tx_irq_en`. `rx_irq` equals the inbound flag AND `rx_irq_en`.
- R10: A synchronous reset empties both queues and clears both flags, so the status word reads 0.
- R11: A push and a pop in the same cycle leave the count unchanged when the queue is neither full nor empty. On a full queue the pop is taken and the push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_hold | input | 1 | Hold outbound queue empty |
| rx_hold | input | 1 | Hold inbound queue empty |
| tx_wr_en | input | 1 | Bus write strobe for outbound data |
| tx_wr_data | input | 32 | Bus write data |
| ser_tx_pop | input | 1 | Serializer takes one outbound word |
| ser_tx_data | output | 32 | Oldest outbound word |
| ser_tx_valid | output | 1 | Outbound queue not empty |
| ser_rx_push | input | 1 | Serializer stores one inbound word |
| ser_rx_data | input | 32 | Inbound word from serializer |
| rx_rd_en | input | 1 | Bus read strobe for inbound data |
| rx_rd_data | output | 32 | Oldest inbound word, 0 when empty |
| tx_level | input | 5 | Outbound request level |
| rx_level | input | 5 | Inbound request level |
| tx_req_clr | input | 1 | Clear pulse for outbound flag |
| rx_req_clr | input | 1 | Clear pulse for inbound flag |
| tx_irq_en | input | 1 | Outbound interrupt enable |
| rx_irq_en | input | 1 | Inbound interrupt enable |
| status_word | output | 32 | Counts and request flags |
| tx_irq | output | 1 | Outbound request interrupt |
| rx_irq | output | 1 | Inbound request interrupt |
| tx_overflow | output | 1 | Dropped write pulse |
| rx_underflow | output | 1 | Empty read pulse |

## Verification
Two pairs of events can land in the same cycle. A clear pulse can arrive while its level condition still holds. The bench does this on purpose and then checks that the flag reads 0 for exactly one cycle and is 1 again on the next. A bus write can also meet a serializer pop while the outbound queue is full. The bench forces this after filling the queue and expects a count of 31, an overflow pulse, and the oldest word removed. Random traffic with clears, holds and level changes then recreates both collisions many times. Every cycle is compared against a queue model that the bench keeps itself.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
    localparam int FIFO_DEPTH = 32;
    localparam int WORD_W     = 32;
    localparam int LEVEL_W    = 5;
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1;

    // outbound requests on a low fill, inbound requests on a high fill
    typedef enum logic { REQ_AT_OR_BELOW, REQ_ABOVE } req_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0] tx_cnt;
        logic             tx_req;
        logic [CNT_W-1:0] rx_cnt;
        logic             rx_req;
    } fifo_stat_t;

    function automatic logic [31:0] pack_status(fifo_stat_t s);
        logic [31:0] w;
        w              = '0;
        w[24 +: CNT_W] = s.tx_cnt;
        w[16]          = s.tx_req;
        w[8 +: CNT_W]  = s.rx_cnt;
        w[0]           = s.rx_req;
        return w;
    endfunction
endpackage

// File: rtl/fifo_core.sv
module fifo_core #(
    parameter int DEPTH = audfifo_pkg::FIFO_DEPTH,
    parameter int WIDTH = audfifo_pkg::WORD_W,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !hold;
    assign do_pop  = pop && !empty && !hold;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R8
    hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (count == '0));
    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !hold) |=> (count == CW'(DEPTH)));
    // R11
    both_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty && !hold) |=> $stable(count));
endmodule

// File: rtl/req_flag.sv
module req_flag
    import audfifo_pkg::*;
#(
    parameter req_kind_e KIND = REQ_AT_OR_BELOW,
    parameter int CW = CNT_W,
    parameter int TW = LEVEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] level,
    input  logic          clr,
    output logic          flag
);
    logic cond;

    generate
        if (KIND == REQ_AT_OR_BELOW) begin : g_low
            assign cond = (count <= CW'(level));
        end else begin : g_high
            assign cond = (count > CW'(level));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (cond) flag <= 1'b1;
    end

    // R7
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);
    // R5
    cond_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cond) |=> flag);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/audio_fifo_req.sv
module audio_fifo_req
    import audfifo_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int WIDTH = WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_hold,
    input  logic               rx_hold,
    input  logic               tx_wr_en,
    input  logic [WIDTH-1:0]   tx_wr_data,
    input  logic               ser_tx_pop,
    output logic [WIDTH-1:0]   ser_tx_data,
    output logic               ser_tx_valid,
    input  logic               ser_rx_push,
    input  logic [WIDTH-1:0]   ser_rx_data,
    input  logic               rx_rd_en,
    output logic [WIDTH-1:0]   rx_rd_data,
    input  logic [LEVEL_W-1:0] tx_level,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic               tx_req_clr,
    input  logic               rx_req_clr,
    input  logic               tx_irq_en,
    input  logic               rx_irq_en,
    output logic [31:0]        status_word,
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               tx_overflow,
    output logic               rx_underflow
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [WIDTH-1:0] rx_head;
    logic             tx_req, rx_req;
    fifo_stat_t       stat;

    fifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
        .clk(clk), .rst(rst), .hold(tx_hold),
        .push(tx_wr_en), .din(tx_wr_data), .pop(ser_tx_pop),
        .dout(ser_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    fifo_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
        .clk(clk), .rst(rst), .hold(rx_hold),
        .push(ser_rx_push), .din(ser_rx_data), .pop(rx_rd_en),
        .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    req_flag #(.KIND(REQ_AT_OR_BELOW), .CW(CW), .TW(LEVEL_W)) u_txreq (
        .clk(clk), .rst(rst), .count(tx_cnt), .level(tx_level),
        .clr(tx_req_clr), .flag(tx_req)
    );

    req_flag #(.KIND(REQ_ABOVE), .CW(CW), .TW(LEVEL_W)) u_rxreq (
        .clk(clk), .rst(rst), .count(rx_cnt), .level(rx_level),
        .clr(rx_req_clr), .flag(rx_req)
    );

    assign ser_tx_valid = !tx_empty;
    assign rx_rd_data   = rx_empty ? '0 : rx_head;
    assign tx_overflow  = tx_wr_en && tx_full;
    assign rx_underflow = rx_rd_en && rx_empty;
    assign tx_irq       = tx_req && tx_irq_en;
    assign rx_irq       = rx_req && rx_irq_en;

    always_comb begin
        stat.tx_cnt = CNT_W'(tx_cnt);
        stat.tx_req = tx_req;
        stat.rx_cnt = CNT_W'(rx_cnt);
        stat.rx_req = rx_req;
        status_word = pack_status(stat);
    end

    // R11
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && ser_rx_push && !rx_rd_en && !rx_hold) |=> rx_full);
endmodule

// File: tb/audio_fifo_req_test.sv
`timescale 1ns/1ps
module audio_fifo_req_test;
    logic        clk = 0;
    logic        rst, tx_hold, rx_hold, tx_wr_en, ser_tx_pop, ser_rx_push, rx_rd_en;
    logic [31:0] tx_wr_data, ser_rx_data;
    logic [4:0]  tx_level, rx_level;
    logic        tx_req_clr, rx_req_clr, tx_irq_en, rx_irq_en;
    logic [31:0] ser_tx_data, rx_rd_data, status_word;
    logic        ser_tx_valid, tx_irq, rx_irq, tx_overflow, rx_underflow;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [31:0] mtx[$], mrx[$];
    bit mtxf = 0, mrxf = 0;

    always #4 clk = ~clk;

    audio_fifo_req uut (.*);

    function automatic logic [31:0] exp_status();
        logic [31:0] w = '0;
        w[29:24] = 6'(mtx.size());
        w[16]    = mtxf;
        w[13:8]  = 6'(mrx.size());
        w[0]     = mrxf;
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        tx_hold = 0; rx_hold = 0; tx_wr_en = 0; ser_tx_pop = 0;
        ser_rx_push = 0; rx_rd_en = 0; tx_req_clr = 0; rx_req_clr = 0;
        tx_wr_data = $urandom; ser_rx_data = $urandom;
    endtask

    // called at a negedge with stimulus applied
    task automatic step();
        int stx, srx;
        bit ctx, crx;
        #1;
        check("R1 R5 R6 R10 status", status_word, exp_status());
        check("R4 underflow", 32'(rx_underflow), 32'(rx_rd_en && mrx.size() == 0));
        if (rx_rd_en)
            check("R2 R4 read data", rx_rd_data, (mrx.size() == 0) ? 32'd0 : mrx[0]);
        check("R3 overflow", 32'(tx_overflow), 32'(tx_wr_en && mtx.size() == 32));
        check("R2 tx valid", 32'(ser_tx_valid), 32'(mtx.size() != 0));
        if (mtx.size() != 0) check("R2 tx order", ser_tx_data, mtx[0]);
        check("R9 tx irq", 32'(tx_irq), 32'(mtxf && tx_irq_en));
        check("R9 rx irq", 32'(rx_irq), 32'(mrxf && rx_irq_en));
        stx = mtx.size(); srx = mrx.size();
        ctx = (stx <= int'(tx_level));
        crx = (srx > int'(rx_level));
        if (rst) begin
            mtx.delete(); mrx.delete(); mtxf = 0; mrxf = 0;
        end else begin
            mtxf = tx_req_clr ? 1'b0 : (mtxf | ctx);
            mrxf = rx_req_clr ? 1'b0 : (mrxf | crx);
            if (tx_hold) mtx.delete();
            else begin
                if (ser_tx_pop && stx > 0) void'(mtx.pop_front());
                if (tx_wr_en && stx < 32) mtx.push_back(tx_wr_data);
            end
            if (rx_hold) mrx.delete();
            else begin
                if (rx_rd_en && srx > 0) void'(mrx.pop_front());
                if (ser_rx_push && srx < 32) mrx.push_back(ser_rx_data);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; tx_level = 15; rx_level = 0; tx_irq_en = 0; rx_irq_en = 0;
        idle();
        repeat (2) @(negedge clk);
        #1 check("R10 reset status", status_word, 32'd0);
        @(negedge clk);
        rst = 0;
        step(); step();                              // R5: empty queue at level 15
        // R1 R3: fill outbound and one extra write
        for (int i = 0; i < 33; i++) begin idle(); tx_wr_en = 1; step(); end
        // R3 R11: write and pop together on a full queue
        idle(); tx_wr_en = 1; ser_tx_pop = 1; step();
        idle(); tx_req_clr = 1; step();              // R7: count high, stays clear
        idle(); step();
        for (int i = 0; i < 32; i++) begin idle(); ser_tx_pop = 1; step(); end
        // R7: clear while condition holds, flag back one cycle later
        idle(); tx_req_clr = 1; step(); idle(); step(); step();
        // R6: level 0, single word; R4 underflow
        idle(); ser_rx_push = 1; step(); idle(); step(); step();
        idle(); rx_irq_en = 1; tx_irq_en = 1; step();  // R9
        idle(); rx_rd_en = 1; step();
        idle(); rx_rd_en = 1; step();
        // R11: push and pop on a partly filled inbound queue
        for (int i = 0; i < 4; i++) begin idle(); ser_rx_push = 1; step(); end
        idle(); ser_rx_push = 1; rx_rd_en = 1; step();
        // R8: hold with traffic
        idle(); rx_hold = 1; ser_rx_push = 1; step();
        idle(); rx_hold = 1; ser_rx_push = 1; rx_rd_en = 1; step();
        idle(); step();
        // random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            tx_wr_en    = ($urandom % 3) == 0;
            ser_tx_pop  = ($urandom % 3) == 0;
            ser_rx_push = ($urandom % 3) == 0;
            rx_rd_en    = ($urandom % 3) == 0;
            tx_req_clr  = ($urandom % 6) == 0;
            rx_req_clr  = ($urandom % 6) == 0;
            tx_hold     = ($urandom % 80) == 0;
            rx_hold     = ($urandom % 80) == 0;
            if (($urandom % 50) == 0) tx_level = 5'($urandom);
            if (($urandom % 50) == 0) rx_level = 5'($urandom);
            if (($urandom % 30) == 0) tx_irq_en = ~tx_irq_en;
            if (($urandom % 30) == 0) rx_irq_en = ~rx_irq_en;
            rst         = ($urandom % 1500) == 0;
            step();
        end
        rst = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule